// File: doc/BRIEF.md
# Stepped Digital Attenuator with Soft Mute

This block is the volume stage of a two-channel audio datapath. Each sample strobe brings a signed left and right sample. Each channel leaves the block multiplied by its current level over full scale. The current level of each channel does not follow its programmed attenuation code at once. It walks toward the code one unit at a time, and the number of sample strobes between walks depends on the selected sample-rate class. A gain change therefore becomes a smooth ramp instead of a click.

A soft-mute request sets the walk target of both channels to zero. When the request is dropped, the target returns to the programmed code. The level reverses from wherever it is, so a short mute pulse only dips the volume. A per-channel invert bit negates that channel's result. The result is clamped to the sample width, so the single overflowing case (most negative sample, full level, inverted) saturates instead of wrapping.

Top module: `stepvol_atten`

## Requirements
- R1: `out_left`/`out_right` load only on a clock edge where `smp_valid` is 1. `out_valid` is 1 in the cycle after each strobe and 0 otherwise, and the outputs hold between strobes.
- R2: Each output equals sample × level / 255, with the quotient truncated toward zero. The level is the channel level held before the capturing edge. Level 255 passes the sample unchanged and level 0 gives 0.
- R3: A step strobe occurs on every Nth sample strobe, counted from reset. N is 4 for `speed_sel` = 00, 8 for 01, and 16 for 10 and 11. Between step strobes no level changes.
- R4: On a step strobe, each level moves by exactly one toward its target and stops at the target. The target is the channel's attenuation code. Rewriting the code mid-ramp redirects the walk from the present level without a jump.
- R5: While `mute_req` is 1 the target of both channels is 0 and no level rises. After release, each level climbs back to its code at the same pace, reversing from its present value if zero was not reached.
- R6: `inv_left`/`inv_right` = 1 negates only that channel's result.
- R7: Results are clamped to the signed 24-bit range, so sample 0x800000 at level 255 with invert set gives 0x7FFFFF.
- R8: A full walk from 255 to 0 takes 1020, 2040 or 4080 sample strobes for `speed_sel` 00, 01 and 10. With a sample of 255×32000, strobe 255N still gives 32000 and strobe 255N+1 gives 0.
- R9: With `rst_n` low at a clock edge, both levels become 255, the step count becomes 0, and both outputs and `out_valid` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one cycle per sample pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| att_left | input | 8 | Left attenuation code, 255 = 0 dB, 0 = mute |
| att_right | input | 8 | Right attenuation code |
| mute_req | input | 1 | Soft-mute request for both channels |
| speed_sel | input | 2 | Rate class: 00 normal, 01 double, 10/11 quad |
| inv_left | input | 1 | Negate the left result |
| inv_right | input | 1 | Negate the right result |
| out_valid | output | 1 | Result strobe, one cycle after smp_valid |
| out_left | output | 24 | Scaled left result |
| out_right | output | 24 | Scaled right result |

## Verification
Every Nth strobe both advances the level and captures an output. The result must use the level from before the step, not the new one. The bench checks this on every strobe of each long ramp against a model that computes the result first and steps afterwards. The full-ramp boundary strobes 255N and 255N+1 show any off-by-one in either order. A mute release arriving mid-ramp is a second collision: the target flips while steps are still in flight. The end level after the reversal must equal the programmed code exactly.

// File: rtl/stepvol_pkg.sv
// Package: shared encodings for the stepped attenuator.
// Assumes the speed select is a two-bit field; code 11 is treated like quad.
package stepvol_pkg;
    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_X = 2'b11
    } speed_e;

    // Number of sample strobes between level steps for a rate class.
    function automatic int unsigned step_period(input speed_e spd, input int unsigned base);
        case (spd)
            SPD_NORMAL: return base;
            SPD_DOUBLE: return base * 2;
            default:    return base * 4;
        endcase
    endfunction
endpackage

// File: rtl/stepvol_pacer.sv
// Module: stepvol_pacer
// Counts sample strobes from reset and raises step_tick on every Nth strobe,
// N chosen from the rate class. Assumes step_tick is used only with smp_valid.
module stepvol_pacer
    import stepvol_pkg::*;
#(
    parameter int unsigned BASE_PERIOD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic [1:0] speed_sel,
    output logic       step_tick
);
    localparam int unsigned MAX_PERIOD = BASE_PERIOD * 4;
    localparam int unsigned CNT_W      = $clog2(MAX_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    // Last count value before wrap for the current rate class.
    always_comb begin
        last_idx = CNT_W'(step_period(speed_e'(speed_sel), BASE_PERIOD) - 1);
    end

    assign step_tick = smp_valid && (cnt_q >= last_idx);

    // Strobe counter, wraps after the last index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (smp_valid) begin
            if (cnt_q >= last_idx) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/stepvol_ramp.sv
// Module: stepvol_ramp
// Holds one channel's current level and walks it one unit toward the target
// on each step tick. Target is zero under mute, else the programmed code.
module stepvol_ramp #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_tick,
    input  logic          mute_req,
    input  logic [CW-1:0] att_code,
    output logic [CW-1:0] level,
    output logic [CW-1:0] target
);
    localparam logic [CW-1:0] FULL = '1;

    logic [CW-1:0] level_q;

    assign target = mute_req ? '0 : att_code;
    assign level  = level_q;

    // Unit walk toward the target, paced by step_tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= FULL;
        end else if (step_tick) begin
            if (level_q < target)      level_q <= level_q + 1'b1;
            else if (level_q > target) level_q <= level_q - 1'b1;
        end
    end
endmodule

// File: rtl/stepvol_scale.sv
// Module: stepvol_scale
// Registers sample * level / full-scale, truncated toward zero, optionally
// negated, clamped to DW bits. Works on the magnitude so truncation is exact.
module stepvol_scale #(
    parameter int unsigned DW = 24,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] sample,
    input  logic [CW-1:0] level,
    input  logic          invert,
    output logic [DW-1:0] result
);
    localparam int unsigned PW   = DW + CW + 1;
    localparam int unsigned FULL = (1 << CW) - 1;
    localparam logic [DW:0] MAXPOS = {2'b00, {(DW-1){1'b1}}};

    logic          neg_in;
    logic          neg_out;
    logic [DW:0]   sext;
    logic [DW:0]   mag;
    logic [PW-1:0] prod;
    logic [DW:0]   quo;
    logic [DW:0]   neg_quo;
    logic [DW-1:0] res_c;

    // Magnitude product, divide, then restore sign with clamp.
    always_comb begin
        neg_in  = sample[DW-1];
        neg_out = neg_in ^ invert;
        sext    = {sample[DW-1], sample};
        mag     = neg_in ? (~sext + 1'b1) : sext;
        prod    = PW'(mag) * PW'(level);
        quo     = (DW+1)'(prod / PW'(FULL));
        neg_quo = ~quo + 1'b1;
        if (neg_out)            res_c = neg_quo[DW-1:0];
        else if (quo > MAXPOS)  res_c = MAXPOS[DW-1:0];
        else                    res_c = quo[DW-1:0];
    end

    // Output register loads on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         result <= '0;
        else if (smp_valid) result <= res_c;
    end
endmodule

// File: rtl/stepvol_atten.sv
// Module: stepvol_atten (top)
// Two-channel stepped attenuator: one shared pacer, a ramp and a scaler per
// channel. Channel 0 is left, channel 1 is right. Assumes one strobe per pair.
module stepvol_atten #(
    parameter int unsigned DW          = 24,
    parameter int unsigned CW          = 8,
    parameter int unsigned BASE_PERIOD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_left,
    input  logic [DW-1:0] smp_right,
    input  logic [CW-1:0] att_left,
    input  logic [CW-1:0] att_right,
    input  logic          mute_req,
    input  logic [1:0]    speed_sel,
    input  logic          inv_left,
    input  logic          inv_right,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right
);
    localparam int unsigned NCH = 2;

    logic                   step_tick;
    logic [NCH-1:0][DW-1:0] smp_all;
    logic [NCH-1:0][DW-1:0] out_all;
    logic [NCH-1:0][CW-1:0] att_all;
    logic [NCH-1:0][CW-1:0] lvl_all;
    logic [NCH-1:0][CW-1:0] tgt_all;
    logic [NCH-1:0]         inv_all;
    logic                   valid_q;

    assign smp_all   = {smp_right, smp_left};
    assign att_all   = {att_right, att_left};
    assign inv_all   = {inv_right, inv_left};
    assign out_left  = out_all[0];
    assign out_right = out_all[1];
    assign out_valid = valid_q;

    stepvol_pacer #(.BASE_PERIOD(BASE_PERIOD)) pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .speed_sel (speed_sel),
        .step_tick (step_tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        stepvol_ramp #(.CW(CW)) ramp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_tick (step_tick),
            .mute_req  (mute_req),
            .att_code  (att_all[c]),
            .level     (lvl_all[c]),
            .target    (tgt_all[c])
        );
        stepvol_scale #(.DW(DW), .CW(CW)) scale_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .sample    (smp_all[c]),
            .level     (lvl_all[c]),
            .invert    (inv_all[c]),
            .result    (out_all[c])
        );
    end

    // Result strobe trails the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= smp_valid;
    end
endmodule

// File: rtl/stepvol_atten_chk.sv
// Module: stepvol_atten_chk
// Property checker for stepvol_atten, attached by bind below.
module stepvol_atten_chk #(
    parameter int unsigned DW  = 24,
    parameter int unsigned CW  = 8,
    parameter int unsigned NCH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   smp_valid,
    input logic                   mute_req,
    input logic                   step_tick,
    input logic                   out_valid,
    input logic [NCH-1:0][CW-1:0] lvl_all,
    input logic [NCH-1:0][CW-1:0] tgt_all,
    input logic [NCH-1:0][DW-1:0] out_all
);
    a_r1_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    a_r1_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
    a_r3_tick_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |-> smp_valid);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
            !step_tick |=> (lvl_all[c] == $past(lvl_all[c])));
        a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_all[c] != $past(lvl_all[c])) |->
            ((lvl_all[c] + CW'(1) == $past(lvl_all[c])) || ($past(lvl_all[c]) + CW'(1) == lvl_all[c])));
        a_r4_toward_target: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_all[c] != $past(lvl_all[c])) |->
            ((lvl_all[c] > $past(lvl_all[c])) == ($past(tgt_all[c]) > $past(lvl_all[c]))));
        a_r5_mute_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mute_req) |-> (lvl_all[c] <= $past(lvl_all[c])));
        a_r2_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(lvl_all[c]) == '0)) |-> (out_all[c] == '0));
    end
endmodule

bind stepvol_atten stepvol_atten_chk #(.DW(DW), .CW(CW), .NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mute_req  (mute_req),
    .step_tick (step_tick),
    .out_valid (out_valid),
    .lvl_all   (lvl_all),
    .tgt_all   (tgt_all),
    .out_all   (out_all)
);

// File: tb/stepvol_atten_tb_top.sv
`timescale 1ns/1ps
// Bench for stepvol_atten: vector table at full level, then directed ramps.
module stepvol_atten_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic [7:0]  att_left = 8'hFF, att_right = 8'hFF;
    logic        mute_req = 1'b0;
    logic [1:0]  speed_sel = 2'b00;
    logic        inv_left = 1'b0, inv_right = 1'b0;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    int checks = 0;
    int failures = 0;
    int m_lvl [2];
    int m_cnt;
    bit done = 1'b0;

    localparam logic [23:0] FS = 24'd8160000; // 255 * 32000

    typedef struct packed {
        logic [23:0] sl;
        logic [23:0] sr;
        logic        il;
        logic        ir;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{24'h000064, 24'hFFFF9C, 1'b0, 1'b0, 24'h000064, 24'hFFFF9C},
        '{24'h7FFFFF, 24'h800000, 1'b0, 1'b0, 24'h7FFFFF, 24'h800000},
        '{24'h7FFFFF, 24'h800000, 1'b1, 1'b1, 24'h800001, 24'h7FFFFF},
        '{24'h000000, 24'h000001, 1'b1, 1'b0, 24'h000000, 24'h000001},
        '{24'hFFFFFF, 24'h000005, 1'b1, 1'b1, 24'h000001, 24'hFFFFFB},
        '{24'h003039, 24'hFF2BCF, 1'b0, 1'b1, 24'h003039, 24'h00D431}
    };

    always #10 clk = ~clk;

    stepvol_atten dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .att_left  (att_left),
        .att_right (att_right),
        .mute_req  (mute_req),
        .speed_sel (speed_sel),
        .inv_left  (inv_left),
        .inv_right (inv_right),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int period(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [23:0] expect_out(input logic [23:0] s, input int lvl, input logic inv);
        longint v;
        v = longint'($signed(s));
        v = (v * lvl) / 255;
        if (inv) v = -v;
        if (v > 8388607)  v = 8388607;
        if (v < -8388608) v = -8388608;
        return v[23:0];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lvl[0] = 255;
        m_lvl[1] = 255;
        m_cnt = 0;
    endtask

    // One strobe; expected result from the pre-step level, then model step.
    task automatic strobe(input logic [23:0] l, input logic [23:0] r, input string req);
        logic [23:0] el, er;
        int tgt;
        @(negedge clk);
        smp_left = l;
        smp_right = r;
        smp_valid = 1'b1;
        el = expect_out(l, m_lvl[0], inv_left);
        er = expect_out(r, m_lvl[1], inv_right);
        m_cnt++;
        if (m_cnt >= period(speed_sel)) begin
            m_cnt = 0;
            for (int c = 0; c < 2; c++) begin
                tgt = mute_req ? 0 : int'(c == 0 ? att_left : att_right);
                if (m_lvl[c] < tgt) m_lvl[c]++;
                else if (m_lvl[c] > tgt) m_lvl[c]--;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
        chk(req, out_left, el);
        chk(req, out_right, er);
    endtask

    task automatic full_ramp(input logic [1:0] spd);
        int n;
        speed_sel = spd;
        att_left = 8'h00;
        att_right = 8'hFF;
        inv_left = 1'b0;
        inv_right = 1'b0;
        mute_req = 1'b0;
        do_reset();
        n = period(spd);
        for (int k = 1; k < 255 * n; k++) strobe(FS, FS, "R3");
        strobe(FS, FS, "R3");
        chk("R8", out_left, 24'd32000);
        strobe(FS, FS, "R3");
        chk("R8", out_left, 24'd0);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        // R9: reset state
        do_reset();
        chk("R9", out_left, 24'd0);
        chk("R9", out_right, 24'd0);
        chk("R9", {23'd0, out_valid}, 24'd0);
        strobe(FS, FS, "R9");

        // Table walk at level 255
        for (int i = 0; i < 6; i++) begin
            inv_left = VECS[i].il;
            inv_right = VECS[i].ir;
            strobe(VECS[i].sl, VECS[i].sr, "R2");
            chk(i == 2 ? "R7" : (i >= 4 ? "R6" : "R2"), out_left, VECS[i].el);
            chk(i == 2 ? "R7" : (i >= 4 ? "R6" : "R2"), out_right, VECS[i].er);
        end
        inv_left = 1'b0;
        inv_right = 1'b0;

        // R1: valid pulse and hold without strobe
        strobe(24'd777, 24'd888, "R1");
        chk("R1", {23'd0, out_valid}, 24'd1);
        smp_left = 24'd5;
        smp_right = 24'd6;
        repeat (3) @(negedge clk);
        chk("R1", {23'd0, out_valid}, 24'd0);
        chk("R1", out_left, 24'd777);
        chk("R1", out_right, 24'd888);

        // R8 / R3: full ramps in each rate class
        full_ramp(2'b00);
        full_ramp(2'b01);
        full_ramp(2'b10);

        // R3: code 11 paces like quad, first step on strobe 16
        speed_sel = 2'b11;
        att_left = 8'h00;
        do_reset();
        for (int k = 0; k < 17; k++) strobe(FS, FS, "R3");
        chk("R3", out_left, 24'd8128000);

        // R4: retarget mid-ramp
        speed_sel = 2'b00;
        att_left = 8'd100;
        att_right = 8'hFF;
        do_reset();
        for (int k = 0; k < 40; k++) strobe(FS, FS, "R4");
        att_left = 8'd250;
        for (int k = 0; k < 60; k++) strobe(FS, FS, "R4");
        strobe(FS, FS, "R4");
        chk("R4", out_left, 24'd8000000);

        // R5: mute, release before zero, climb back
        att_left = 8'd200;
        att_right = 8'd200;
        do_reset();
        for (int k = 0; k < 240; k++) strobe(FS, FS, "R5");
        mute_req = 1'b1;
        for (int k = 0; k < 100; k++) strobe(FS, FS, "R5");
        mute_req = 1'b0;
        for (int k = 0; k < 120; k++) strobe(FS, FS, "R5");
        chk("R5", out_left, 24'd6400000);
        chk("R5", out_right, 24'd6400000);

        done = 1'b1;
        finish_up();
    end
endmodule